// File: doc/BRIEF.md
# Legacy Interrupt Message Generator

This block turns a vector of level-sensitive legacy interrupt lines, one line per function, into a stream of interrupt messages. When a function's line goes high, the block emits an assert message. When the line goes low, it emits a deassert message. Each message carries the number of the requesting function and a traffic class of zero. Messages leave on a valid/ready stream, so the consumer that builds packets can stall the block at any time.

For each function the block keeps the level it last reported downstream. A function has work pending whenever its gated input differs from that reported level. The reported level changes only when the consumer accepts a message. As a result, no transition is lost while the stream is stalled. A pulse that comes and goes before its message is loaded produces nothing.

A per-function disable input forces the effective level low. Pending functions are served lowest index first.

Top module: `intx_msg_gen`

## Requirements
- R1: After reset, `msg_valid` is low and every function's reported level is low.
- R2: When a function's effective level (`irq_sts[i] & ~irq_dis[i]`) rises above its reported level, exactly one message is sent with `msg_assert`=1, `msg_func`=i and `msg_tc`=0.
- R3: When a function's effective level falls below a reported high level, exactly one message is sent with `msg_assert`=0 and `msg_func`=i.
- R4: While `msg_valid` is high and `msg_ready` is low, the next cycle keeps `msg_valid` high and leaves `msg_assert` and `msg_func` unchanged.
- R5: A function whose effective level equals its reported level produces no message, however long the level is held.
- R6: When several functions are pending, the lowest function index is sent first.
- R7: If an effective level returns to its reported value before a message for it is loaded, no message is sent for that function.
- R8: Setting `irq_dis[i]` for a function reported high sends a deassert message. A rising `irq_sts[i]` while disabled sends nothing. Clearing the disable with the status still high sends an assert message.
- R9: A function's reported level changes only on the cycle its message is accepted (`msg_valid & msg_ready`), and it takes the message's kind. A transition that arrives while a message for that function is waiting is therefore sent after it.
- R10: When the output is empty and work is pending, a message is presented one clock later. After each accepted message there is exactly one idle cycle before the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_sts | input | NUM_FUNC | Level interrupt status, bit i for function i |
| irq_dis | input | NUM_FUNC | Per-function interrupt disable, forces level low |
| msg_valid | output | 1 | A message is presented |
| msg_ready | input | 1 | Consumer accepts the presented message |
| msg_assert | output | 1 | 1 = assert message, 0 = deassert message |
| msg_func | output | FN_W | Function number of the message |
| msg_tc | output | 3 | Traffic class, always 0 |

## Verification
Two things can happen in the same cycle: the consumer accepts a message for a function, and that same function's input changes again. The bench provokes this by stalling with a deassert message for function 0 waiting, then raising `msg_ready` and the function 0 input together. The scoreboard must then see the deassert followed by a fresh assert. A second overlap, where a pulse on another function comes and goes entirely behind a stalled message, must produce no message at all.

// File: rtl/intx_pkg.sv
// Shared constants and types for the legacy interrupt message generator.
// Assumes nothing beyond a single clock domain.
package intx_pkg;
    // Kind of message carried on the output stream.
    typedef enum logic {
        MSG_DEASSERT = 1'b0,
        MSG_ASSERT   = 1'b1
    } msg_kind_e;

    // Interrupt messages always travel on traffic class zero.
    localparam logic [2:0] INTX_TC = 3'd0;
endpackage

// File: rtl/intx_track.sv
// Reported-level tracker: holds, per function, the level last accepted
// downstream. Pending work is wherever the effective level and the
// reported level differ. Assumes acc_fn < N whenever acc_valid is high.
module intx_track #(
    parameter  int N  = 4,
    localparam int FW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] eff_lvl,
    input  logic         acc_valid,
    input  logic [FW-1:0] acc_fn,
    input  logic         acc_kind,
    output logic [N-1:0] pending
);
    logic [N-1:0] reported;

    // Update the reported flag of the accepted function only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reported <= '0;
        end else if (acc_valid) begin
            reported[acc_fn] <= acc_kind;
        end
    end

    // Pending work: the effective level disagrees with what was reported.
    always_comb pending = eff_lvl ^ reported;

    // R9: an accepted message sets the flag to its kind.
    p_flag_takes_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> reported[$past(acc_fn)] == $past(acc_kind));

    // R9: without an acceptance, the flags do not move.
    p_flag_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(reported));
endmodule

// File: rtl/intx_pick.sv
// Fixed-priority selector: picks the lowest-index pending function and
// reports the kind of message it needs (its current effective level).
module intx_pick #(
    parameter  int N  = 4,
    localparam int FW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pending,
    input  logic [N-1:0]  eff_lvl,
    output logic          pick_valid,
    output logic [FW-1:0] pick_fn,
    output logic          pick_kind
);
    // Walk from index 0 upward and keep the first pending function.
    always_comb begin
        pick_valid = 1'b0;
        pick_fn    = '0;
        for (int i = 0; i < N; i++) begin
            if (!pick_valid && pending[i]) begin
                pick_valid = 1'b1;
                pick_fn    = FW'(i);
            end
        end
        pick_kind = eff_lvl[pick_fn];
    end

    // R6: the chosen function is pending and no lower index is pending.
    p_lowest_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (pending[pick_fn] &&
                        ((pending & ((N'(1) << pick_fn) - N'(1))) == '0)));
endmodule

// File: rtl/intx_out.sv
// Output holding register for the message stream. It loads a new message
// only when empty, so every acceptance is followed by one idle cycle. This
// keeps a freshly accepted function from being picked again before its
// reported flag has settled.
module intx_out #(
    parameter int FW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cand_valid,
    input  logic [FW-1:0] cand_fn,
    input  logic          cand_kind,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [FW-1:0] out_fn,
    output logic          out_kind
);
    // Load when empty, drop on acceptance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fn    <= '0;
            out_kind  <= 1'b0;
        end else if (!out_valid) begin
            out_valid <= cand_valid;
            out_fn    <= cand_fn;
            out_kind  <= cand_kind;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R4: a stalled message stays put.
    p_hold_stalled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_fn) && $stable(out_kind)));

    // R10: one idle cycle follows every acceptance.
    p_bubble_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);
endmodule

// File: rtl/intx_msg_gen.sv
// Legacy interrupt message generator top. It gates each function's
// status with its disable, tracks reported levels, picks the lowest
// pending function and presents one message at a time on a valid/ready
// stream. Assumes synchronous level inputs in the clk domain.
module intx_msg_gen #(
    parameter  int NUM_FUNC = 4,
    localparam int FN_W     = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_FUNC-1:0] irq_sts,
    input  logic [NUM_FUNC-1:0] irq_dis,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic                msg_assert,
    output logic [FN_W-1:0]     msg_func,
    output logic [2:0]          msg_tc
);
    import intx_pkg::*;

    logic [NUM_FUNC-1:0] eff_lvl;
    logic [NUM_FUNC-1:0] pending;
    logic                pick_valid;
    logic [FN_W-1:0]     pick_fn;
    logic                pick_kind;
    logic                accept;

    // Input gating: a disabled function reads as a low level.
    for (genvar g = 0; g < NUM_FUNC; g++) begin : g_gate
        assign eff_lvl[g] = irq_sts[g] & ~irq_dis[g];
    end

    // Handshake completes when a presented message is taken.
    always_comb accept = msg_valid & msg_ready;

    intx_track #(.N(NUM_FUNC)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .eff_lvl   (eff_lvl),
        .acc_valid (accept),
        .acc_fn    (msg_func),
        .acc_kind  (msg_assert),
        .pending   (pending)
    );

    intx_pick #(.N(NUM_FUNC)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .eff_lvl    (eff_lvl),
        .pick_valid (pick_valid),
        .pick_fn    (pick_fn),
        .pick_kind  (pick_kind)
    );

    intx_out #(.FW(FN_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_valid (pick_valid),
        .cand_fn    (pick_fn),
        .cand_kind  (pick_kind),
        .out_ready  (msg_ready),
        .out_valid  (msg_valid),
        .out_fn     (msg_func),
        .out_kind   (msg_assert)
    );

    // Traffic class is fixed for legacy interrupt messages.
    always_comb msg_tc = INTX_TC;

    // R2/R3: a newly presented message matches the level seen when loaded.
    p_kind_matches_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |->
            (msg_assert == (($past(eff_lvl) & (NUM_FUNC'(1) << msg_func)) != '0)));

    // R10: an empty output with pending work is filled on the next edge.
    p_fill_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid && (pending != '0)) |=> msg_valid);
endmodule

// File: tb/intx_msg_gen_tb_top.sv
module intx_msg_gen_tb_top;
    localparam int NF = 4;
    localparam int FW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] irq_sts = '0;
    logic [NF-1:0] irq_dis = '0;
    logic          msg_ready = 1'b1;
    logic          msg_valid;
    logic          msg_assert;
    logic [FW-1:0] msg_func;
    logic [2:0]    msg_tc;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [FW:0] exp_q[$];
    string       tag_q[$];

    logic          prev_stall = 1'b0;
    logic          prev_kind  = 1'b0;
    logic [FW-1:0] prev_fn    = '0;

    always #2 clk = ~clk;

    intx_msg_gen #(.NUM_FUNC(NF)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_sts    (irq_sts),
        .irq_dis    (irq_dis),
        .msg_valid  (msg_valid),
        .msg_ready  (msg_ready),
        .msg_assert (msg_assert),
        .msg_func   (msg_func),
        .msg_tc     (msg_tc)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic kind, input int fn, input string req);
        exp_q.push_back({kind, FW'(fn)});
        tag_q.push_back(req);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare accepted messages against the scoreboard, check stalls.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                check(msg_valid && msg_func == prev_fn && msg_assert == prev_kind,
                      "R4", "stalled message held", {msg_valid, msg_assert, msg_func},
                      {1'b1, prev_kind, prev_fn});
            end
            if (msg_valid && msg_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected message", {msg_assert, msg_func}, -1);
                end else begin
                    logic [FW:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({msg_assert, msg_func} == e && msg_tc == 3'd0, t, "message",
                          {msg_tc, msg_assert, msg_func}, {3'd0, e});
                end
            end
            prev_stall = msg_valid && !msg_ready;
            prev_kind  = msg_assert;
            prev_fn    = msg_func;
        end
    end

    task automatic wait_idle();
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !msg_valid) break;
        end
        check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k == 9) check(!msg_valid, "R5", "quiet when levels settled", msg_valid, 0);
        end
        step();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        @(negedge clk);
        check(!msg_valid, "R1", "valid in reset", msg_valid, 0);
        step();
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) @(negedge clk);
        check(!msg_valid, "R1", "valid after reset", msg_valid, 0);
        step();

        // Single rise and fall.
        irq_sts[2] = 1'b1; push(1'b1, 2, "R2");
        wait_idle();
        irq_sts[2] = 1'b0; push(1'b0, 2, "R3");
        wait_idle();

        // Two simultaneous rises: lowest first, with fill and bubble timing.
        irq_sts = 4'b1010; push(1'b1, 1, "R6"); push(1'b1, 3, "R6");
        @(posedge clk); @(negedge clk);
        check(msg_valid && msg_func == 2'd1, "R10", "filled one edge later",
              {msg_valid, msg_func}, {1'b1, 2'd1});
        @(negedge clk);
        check(!msg_valid, "R10", "idle cycle after accept", msg_valid, 0);
        @(negedge clk);
        check(msg_valid && msg_func == 2'd3, "R10", "next message after bubble",
              {msg_valid, msg_func}, {1'b1, 2'd3});
        wait_idle();
        irq_sts = 4'b0000; push(1'b0, 1, "R6"); push(1'b0, 3, "R6");
        wait_idle();

        // Stall with a waiting message; a pulse elsewhere must vanish.
        msg_ready = 1'b0;
        irq_sts[0] = 1'b1; push(1'b1, 0, "R4");
        repeat (3) step();
        irq_sts[2] = 1'b1;
        repeat (2) step();
        irq_sts[2] = 1'b0;
        repeat (3) step();
        msg_ready = 1'b1;
        wait_idle();
        check(1'b1, "R7", "pulse behind stall produced nothing", 0, 0);

        // Acceptance and a new input change in the same cycle.
        msg_ready = 1'b0;
        irq_sts[0] = 1'b0; push(1'b0, 0, "R9");
        repeat (3) step();
        msg_ready = 1'b1;
        irq_sts[0] = 1'b1; push(1'b1, 0, "R9");
        wait_idle();

        // Disable gating.
        irq_dis[0] = 1'b1; push(1'b0, 0, "R8");
        wait_idle();
        irq_dis[3] = 1'b1;
        irq_sts[3] = 1'b1;
        wait_idle();
        irq_dis[3] = 1'b0; push(1'b1, 3, "R8");
        wait_idle();
        irq_dis[0] = 1'b0; push(1'b1, 0, "R8");
        wait_idle();

        check(exp_q.size() == 0, "R5", "no leftover expectations", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule